// File: doc/BRIEF.md
# Flash Command Interface Write Latch

This block is the bus-write front end of a flash command interface, built as a synchronous model that runs on a fast system clock. It oversamples five active-low host controls: chip select, write strobe, address latch strobe, read enable and output kill. It also samples a 19-bit address bus and a 32-bit data bus. From the first rising edges of the right control signals it rebuilds each write cycle. The result goes to a downstream command decoder as one event that carries the latched address and data word.

The address is latched on the first rising edge of the address latch strobe, write strobe or chip select, whichever comes first. The data word is latched only on the first rising edge of the write strobe or chip select. A write cycle must keep read enable inactive (high) and output kill asserted (low) for its whole length. If either leaves that state during the cycle, the cycle is aborted. The block also drives the enable for the bidirectional data-bus output drivers.

Events leave through a valid/ready port. Once `evt_valid_o` is raised, it stays high and the payload stays frozen until a cycle in which `evt_ready_i` is high. The host bus cannot be stalled, so a write that completes while an earlier event is still waiting is discarded and reported, never queued.

Top module: `flash_wr_front`

## Requirements
- R1: In a plain write (chip select, write strobe and address latch strobe all low), the address and the data word are both taken from the bus at the first rising edge of chip select or write strobe (or both together), and exactly one event carries them.
- R2: In a latched-address write, the address is taken at the first rising edge of the address latch strobe. A different value placed on the address bus later in the same cycle does not change the address that the event carries.
- R3: A rising edge of the address latch strobe never captures data and never produces an event by itself. Data is taken only at the write-strobe or chip-select edge that ends the write.
- R4: If read enable goes low or output kill goes high while a cycle is open, `abort_o` pulses for one clock and no event is produced. Every edge after that is ignored until chip select, write strobe and address latch strobe have all returned high.
- R5: `dq_oe_o` is high exactly when read enable is low and output kill is high, two clock edges after the pins change.
- R6: `evt_valid_o` stays high with `evt_addr_o` and `evt_data_o` unchanged until a clock edge at which `evt_ready_i` is high. Each completed write gives exactly one handshake.
- R7: If a write completes while an event is still waiting, the new write is discarded, `drop_o` pulses for one clock, and the waiting event is kept unchanged.
- R8: After reset, `evt_valid_o`, `abort_o`, `drop_o` and `dq_oe_o` are all low.
- R9: If chip select rises while the write strobe is high (a cycle with no write strobe), the cycle ends with no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n_i | input | 1 | Chip select, active low |
| we_n_i | input | 1 | Write strobe, active low |
| le_n_i | input | 1 | Address latch strobe, active low |
| oe_n_i | input | 1 | Read enable, active low |
| odis_n_i | input | 1 | Output kill, active low (low forces the outputs off) |
| addr_i | input | 19 | Host address bus |
| data_i | input | 32 | Host data bus (write direction) |
| evt_valid_o | output | 1 | Write event is valid |
| evt_ready_i | input | 1 | Downstream accepts the event |
| evt_addr_o | output | 19 | Latched address of the event |
| evt_data_o | output | 32 | Latched command or data word of the event |
| abort_o | output | 1 | One-clock pulse when a cycle is aborted by the output controls |
| drop_o | output | 1 | One-clock pulse when a completed write is discarded |
| dq_oe_o | output | 1 | Data-bus output driver enable |

## Verification
The assertions assume that the host holds the address and data buses steady for at least three system clocks around each control edge that captures them. They also assume that every control level lasts at least three system clocks, so the synchronizers never miss a pulse. The stimulus changes pins only one clock tick after a rising edge and holds every level for three or more clocks. It waits for each event to be accepted before it starts another write, except in the deliberate overrun case. Random phases vary the edge order, the write style and the ready pattern. The output-control pins change only while chip select is high, or on purpose to trigger an abort.

// File: rtl/flash_wr_pkg.sv
package flash_wr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CYC  = 2'd1,
    ST_HALT = 2'd2
  } wr_state_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic le_n;
    logic oe_n;
    logic odis_n;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
  localparam logic [CTL_W-1:0] CTL_RST = 5'b11110;

endpackage

// File: rtl/flash_wr_sync.sv
module flash_wr_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/flash_wr_ctl.sv
module flash_wr_ctl
  import flash_wr_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] cm_addr_o,
  output logic [DATA_W-1:0] cm_data_o,
  output logic              abort_o
);
  wr_state_e st, st_nxt;
  ctl_t prv;
  logic held;
  logic [ADDR_W-1:0] held_addr;
  logic ce_r, we_r, le_r, guard_bad;
  logic cap_a, clr_a, commit_c, abort_c;

  assign ce_r = ctl_i.ce_n & ~prv.ce_n;
  assign we_r = ctl_i.we_n & ~prv.we_n;
  assign le_r = ctl_i.le_n & ~prv.le_n;
  assign guard_bad = ~ctl_i.oe_n | ctl_i.odis_n;

  always_comb begin
    st_nxt = st;
    cap_a = 1'b0;
    clr_a = 1'b0;
    commit_c = 1'b0;
    abort_c = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (!ctl_i.ce_n && (!ctl_i.we_n || !ctl_i.le_n)) begin
          if (guard_bad) begin
            abort_c = 1'b1;
            st_nxt = ST_HALT;
          end else begin
            st_nxt = ST_CYC;
          end
        end
      end
      ST_CYC: begin
        if (guard_bad) begin
          abort_c = 1'b1;
          clr_a = 1'b1;
          st_nxt = ST_HALT;
        end else begin
          if (!held && (ce_r || we_r || le_r)) cap_a = 1'b1;
          if ((ce_r || we_r) && !prv.ce_n && !prv.we_n) begin
            commit_c = 1'b1;
            clr_a = 1'b1;
            st_nxt = ST_IDLE;
          end else if (ce_r) begin
            clr_a = 1'b1;
            st_nxt = ST_IDLE;
          end
        end
      end
      ST_HALT: begin
        clr_a = 1'b1;
        if (ctl_i.ce_n && ctl_i.we_n && ctl_i.le_n) st_nxt = ST_IDLE;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      prv <= ctl_t'(CTL_RST);
      held <= 1'b0;
      held_addr <= '0;
      abort_o <= 1'b0;
    end else begin
      st <= st_nxt;
      prv <= ctl_i;
      abort_o <= abort_c;
      if (clr_a) begin
        held <= 1'b0;
      end else if (cap_a) begin
        held <= 1'b1;
        held_addr <= addr_i;
      end
    end
  end

  assign commit_o  = commit_c;
  assign cm_addr_o = held ? held_addr : addr_i;
  assign cm_data_o = data_i;

  // R4
  commit_abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit_c, abort_c}));

  // R4
  commit_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_c |-> (prv.oe_n && !prv.odis_n));
endmodule

// File: rtl/flash_wr_evq.sv
module flash_wr_evq #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              drop_o
);
  logic busy;
  assign busy = valid_o && !ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
      drop_o <= 1'b0;
    end else begin
      drop_o <= commit_i && busy;
      if (commit_i && !busy) begin
        valid_o <= 1'b1;
        addr_o <= addr_i;
        data_o <= data_i;
      end else if (valid_o && ready_i) begin
        valid_o <= 1'b0;
      end
    end
  end

  // R6
  evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(data_o)));

  // R6
  evt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !busy) |=> (valid_o && addr_o == $past(addr_i) && data_o == $past(data_i)));

  // R7
  drop_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |-> valid_o);
endmodule

// File: rtl/flash_wr_front.sv
module flash_wr_front
  import flash_wr_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n_i,
  input  logic              we_n_i,
  input  logic              le_n_i,
  input  logic              oe_n_i,
  input  logic              odis_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              evt_valid_o,
  input  logic              evt_ready_i,
  output logic [ADDR_W-1:0] evt_addr_o,
  output logic [DATA_W-1:0] evt_data_o,
  output logic              abort_o,
  output logic              drop_o,
  output logic              dq_oe_o
);
  localparam int BUS_W = ADDR_W + DATA_W;

  logic [CTL_W-1:0] ctl_raw, ctl_q;
  logic [BUS_W-1:0] bus_q;
  ctl_t ctl_s;
  logic commit;
  logic [ADDR_W-1:0] cm_addr;
  logic [DATA_W-1:0] cm_data;

  assign ctl_raw = {ce_n_i, we_n_i, le_n_i, oe_n_i, odis_n_i};

  flash_wr_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) i_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_q));

  flash_wr_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_bus_dly (
    .clk(clk), .rst_n(rst_n), .d({addr_i, data_i}), .q(bus_q));

  assign ctl_s = ctl_t'(ctl_q);

  flash_wr_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_i(ctl_s),
    .addr_i(bus_q[BUS_W-1:DATA_W]), .data_i(bus_q[DATA_W-1:0]),
    .commit_o(commit), .cm_addr_o(cm_addr), .cm_data_o(cm_data),
    .abort_o(abort_o));

  flash_wr_evq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_evq (
    .clk(clk), .rst_n(rst_n), .commit_i(commit),
    .addr_i(cm_addr), .data_i(cm_data),
    .valid_o(evt_valid_o), .ready_i(evt_ready_i),
    .addr_o(evt_addr_o), .data_o(evt_data_o), .drop_o(drop_o));

  assign dq_oe_o = ~ctl_s.oe_n & ctl_s.odis_n;

  // R4
  abort_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> !drop_o);
endmodule

// File: tb/test_flash_wr_front.sv
`timescale 1ns/1ps
module test_flash_wr_front;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, ce_n, we_n, le_n, oe_n, odis_n, evt_ready;
  logic [18:0] addr;
  logic [31:0] data;
  logic evt_valid, abort_p, drop_p, dq_oe;
  logic [18:0] evt_addr;
  logic [31:0] evt_data;

  flash_wr_front i_flash_wr_front (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n), .we_n_i(we_n), .le_n_i(le_n),
    .oe_n_i(oe_n), .odis_n_i(odis_n), .addr_i(addr), .data_i(data),
    .evt_valid_o(evt_valid), .evt_ready_i(evt_ready), .evt_addr_o(evt_addr),
    .evt_data_o(evt_data), .abort_o(abort_p), .drop_o(drop_p), .dq_oe_o(dq_oe));

  int checks = 0, errors = 0;
  int hs_cnt = 0, abort_cnt = 0, drop_cnt = 0;
  int ready_mode = 1;
  logic [18:0] last_addr;
  logic [31:0] last_data;

  always @(negedge clk) if (rst_n) begin
    if (evt_valid && evt_ready) begin
      hs_cnt++;
      last_addr = evt_addr;
      last_data = evt_data;
    end
    if (abort_p) abort_cnt++;
    if (drop_p) drop_cnt++;
  end

  always begin
    @(posedge clk); #1;
    case (ready_mode)
      0: evt_ready = 1'b0;
      1: evt_ready = 1'b1;
      default: evt_ready = 1'($urandom_range(0, 1));
    endcase
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  function automatic logic [18:0] garble(input logic [18:0] a);
    return ~a ^ 19'h15a5a;
  endfunction

  // order: 0 write strobe first, 1 chip select first, 2 both together
  task automatic plain_write(input logic [18:0] a, input logic [31:0] d, input int order);
    addr = a; data = d;
    ce_n = 0; we_n = 0; le_n = 0; wt(3);
    if (order == 0) we_n = 1; else if (order == 1) ce_n = 1; else begin we_n = 1; ce_n = 1; end
    wt(3);
    we_n = 1; ce_n = 1; wt(3);
    le_n = 1; addr = garble(a); data = ~d; wt(3);
  endtask

  task automatic latch_write(input logic [18:0] a, input logic [31:0] d, input int order);
    addr = a; ce_n = 0; le_n = 0; wt(3);
    le_n = 1; wt(3);
    addr = garble(a); data = d; we_n = 0; wt(3);
    if (order == 0) we_n = 1; else if (order == 1) ce_n = 1; else begin we_n = 1; ce_n = 1; end
    wt(3);
    we_n = 1; ce_n = 1; data = ~d; wt(3);
  endtask

  task automatic expect_evt(input int prev, input logic [18:0] a, input logic [31:0] d, input string req);
    for (int i = 0; i < 60 && hs_cnt == prev; i++) wt(1);
    wt(2);
    chk(hs_cnt == prev + 1, {req, " event count"}, 64'(hs_cnt), 64'(prev + 1));
    chk(last_addr == a, {req, " address"}, 64'(last_addr), 64'(a));
    chk(last_data == d, {req, " data"}, 64'(last_data), 64'(d));
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog expired act=0 exp=1");
    summary();
  end

  initial begin
    int prev, ab, dr;
    logic [18:0] a0;
    logic [31:0] d0;
    void'($urandom(32'd7061));
    rst_n = 0; ce_n = 1; we_n = 1; le_n = 1; oe_n = 1; odis_n = 0;
    addr = '0; data = '0;
    wt(5); rst_n = 1; wt(2);

    // R8 reset state
    chk(evt_valid == 0, "R8 valid", 64'(evt_valid), 0);
    chk(dq_oe == 0, "R8 dq_oe", 64'(dq_oe), 0);
    chk(abort_cnt == 0 && drop_cnt == 0, "R8 pulses", 64'(abort_cnt + drop_cnt), 0);

    // R5 output driver enable
    oe_n = 0; odis_n = 1; wt(3);
    chk(dq_oe == 1, "R5 enabled", 64'(dq_oe), 1);
    odis_n = 0; wt(3);
    chk(dq_oe == 0, "R5 killed", 64'(dq_oe), 0);
    oe_n = 1; odis_n = 1; wt(3);
    chk(dq_oe == 0, "R5 read off", 64'(dq_oe), 0);
    odis_n = 0; wt(3);

    // R1 plain writes, each edge order
    for (int o = 0; o < 3; o++) begin
      prev = hs_cnt;
      plain_write(19'h1000 + 19'(o), 32'hC0DE_0000 + 32'(o), o);
      expect_evt(prev, 19'h1000 + 19'(o), 32'hC0DE_0000 + 32'(o), "R1");
    end

    // R2 latched address, later bus change ignored
    for (int o = 0; o < 3; o++) begin
      prev = hs_cnt;
      latch_write(19'h7_2200 + 19'(o), 32'hA5A5_1000 + 32'(o), o);
      expect_evt(prev, 19'h7_2200 + 19'(o), 32'hA5A5_1000 + 32'(o), "R2");
    end

    // R3 / R9 strobe pulse then chip select rises with no write strobe
    prev = hs_cnt;
    addr = 19'h00042; data = 32'h1111_2222;
    ce_n = 0; le_n = 0; wt(3); le_n = 1; wt(3); ce_n = 1; wt(6);
    chk(hs_cnt == prev && evt_valid == 0, "R3 R9 no event", 64'(hs_cnt), 64'(prev));

    // R4 abort by read enable
    prev = hs_cnt; ab = abort_cnt;
    addr = 19'h3; data = 32'h3;
    ce_n = 0; we_n = 0; le_n = 0; wt(3);
    oe_n = 0; wt(3);
    we_n = 1; ce_n = 1; le_n = 1; wt(3); oe_n = 1; wt(4);
    chk(abort_cnt == ab + 1, "R4 abort pulse oe", 64'(abort_cnt), 64'(ab + 1));
    chk(hs_cnt == prev && evt_valid == 0, "R4 no event oe", 64'(hs_cnt), 64'(prev));

    // R4 abort by output kill, later edges ignored while controls stay low
    prev = hs_cnt; ab = abort_cnt;
    ce_n = 0; we_n = 0; le_n = 0; wt(3);
    odis_n = 1; wt(3); odis_n = 0; wt(3);
    we_n = 1; wt(3); ce_n = 1; le_n = 1; wt(6);
    chk(abort_cnt == ab + 1, "R4 abort pulse kill", 64'(abort_cnt), 64'(ab + 1));
    chk(hs_cnt == prev && evt_valid == 0, "R4 edges ignored", 64'(hs_cnt), 64'(prev));

    // R6 back-pressure holds payload
    ready_mode = 0; prev = hs_cnt;
    plain_write(19'h5_5555, 32'hDEAD_BEEF, 0);
    chk(evt_valid == 1 && evt_addr == 19'h5_5555, "R6 held valid", 64'(evt_addr), 64'h55555);
    wt(5);
    chk(evt_valid == 1 && evt_data == 32'hDEAD_BEEF, "R6 stable data", 64'(evt_data), 64'hDEADBEEF);
    ready_mode = 1;
    expect_evt(prev, 19'h5_5555, 32'hDEAD_BEEF, "R6");

    // R7 overrun drops the second write
    ready_mode = 0; prev = hs_cnt; dr = drop_cnt;
    plain_write(19'h0_0AAA, 32'h0000_AAAA, 2);
    latch_write(19'h0_0BBB, 32'h0000_BBBB, 0);
    chk(drop_cnt == dr + 1, "R7 drop pulse", 64'(drop_cnt), 64'(dr + 1));
    chk(evt_addr == 19'h0_0AAA, "R7 pending kept", 64'(evt_addr), 64'h0AAA);
    ready_mode = 1;
    expect_evt(prev, 19'h0_0AAA, 32'h0000_AAAA, "R7");
    wt(10);
    chk(hs_cnt == prev + 1, "R7 single handshake", 64'(hs_cnt), 64'(prev + 1));

    // random writes, R1 R2 R6
    ready_mode = 2;
    for (int i = 0; i < 40; i++) begin
      a0 = 19'($urandom);
      d0 = $urandom;
      prev = hs_cnt;
      if ($urandom_range(0, 1) == 0) begin
        plain_write(a0, d0, int'($urandom_range(0, 2)));
        expect_evt(prev, a0, d0, "R1 random");
      end else begin
        latch_write(a0, d0, int'($urandom_range(0, 2)));
        expect_evt(prev, a0, d0, "R2 random");
      end
    end
    summary();
  end
endmodule